// File: doc/BRIEF.md
# Memory-Controller Event Counter Bank

This block is a bank of four 32-bit event counters placed beside a DRAM controller. The controller exposes many single-cycle event pulses. Each counter has its own configuration word that holds an enable bit and an 8-bit event code, and the code picks the event that the counter adds up. Counter 0 ignores its code and always counts clock cycles. Its enable bit is the run control for the whole bank: no counter advances while counter 0 is disabled.

Counter 0 sets the length of a measurement window. When it rolls over from all ones to zero, the bank freezes and an interrupt is raised. Every count stays readable while the bank is frozen. Writing 1 to the status bit lowers the interrupt and lets the bank run again. The other counters wrap silently when they overflow.

Two event codes count AXI requests whose ID passes a filter. The filter is one ID/mask pair shared by all counters. The read and write request channels are observed only: a request counts on a clock where both its valid and its ready are high. The block never drives ready, so it applies no back-pressure.

Top module: `mc_perf_bank`

## Requirements
- R1: After reset, all counters, configuration words, the filter word and the status bit read as 0, and `irq` is low.
- R2: When counter 0 is enabled (bit 0 of its configuration word) and the bank is not frozen, counter 0 increases by one on every clock, whatever its event code holds.
- R3: Counter n (n = 1..3) increases by one on a clock where all of these hold: its own enable bit is set, counter 0 is enabled, the bank is not frozen, and its selected event is active. An event code c below 64 (configuration bits [15:8]) selects `evt_pulse[c]`.
- R4: When counter 0 rolls over from 0xFFFFFFFF to 0, `irq` and the frozen status bit are high from the next clock on. While the bank is frozen, no counter changes except through a register write.
- R5: When counter 1, 2 or 3 rolls over from 0xFFFFFFFF, it wraps to 0 and keeps counting, and `irq` stays low.
- R6: Event code 0x41 counts clocks where `ar_valid` and `ar_ready` are both high and the read ID passes the filter. Event code 0x42 does the same for `aw_valid`, `aw_ready` and the write ID.
- R7: An ID passes the filter when (ID AND mask) equals (filter ID AND mask). A mask bit of 1 means that bit is compared, so a mask of 0 passes every ID.
- R8: A single filter word at address 8 (ID in bits [15:0], mask in bits [31:16]) applies to every counter and to both request channels.
- R9: Writing the status word at address 9 with bit 0 set lowers `irq` and ends the freeze from the next clock on. Writing it with bit 0 clear changes nothing.
- R10: If counter 0 rolls over on the same clock as another counter's event, that other counter still takes that increment before the bank freezes.
- R11: The register map is: configuration words at addresses 0..3, counter values at 4..7 and status bit 0 at 9. Reads are combinational. A write to a counter address loads the written value and takes priority over an increment. An event code of 64 or above, other than 0x41 and 0x42, counts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 64 | Single-cycle event pulses from the controller |
| ar_valid | input | 1 | Read request valid (observed) |
| ar_ready | input | 1 | Read request ready (observed) |
| ar_id | input | 16 | Read request ID |
| aw_valid | input | 1 | Write request valid (observed) |
| aw_ready | input | 1 | Write request ready (observed) |
| aw_id | input | 16 | Write request ID |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt; stays high while the bank is frozen |

## Verification
Counter increments, register writes, the freeze and its release all show up one clock after the edge that samples the stimulus. Read data shows the current state in the same cycle, with no extra delay. The bench drives inputs two time units after each rising edge, so they are stable before the next edge. After that edge it steps a behavioural reference model, then compares `irq` and the read data for the current address with the model. Directed checks are also placed at the exact cycle that follows from counting these one-clock delays, such as the cycle where the interrupt from a preloaded counter 0 is first due.

// File: rtl/mc_perf_pkg.sv
package mc_perf_pkg;
  localparam int NUM_CNT  = 4;
  localparam int CNT_W    = 32;
  localparam int ID_W     = 16;
  localparam int CODE_W   = 8;
  localparam int NUM_EVT  = 64;
  localparam int DATA_W   = 32;
  localparam logic [CODE_W-1:0] CODE_RD_FLT = 8'h41;
  localparam logic [CODE_W-1:0] CODE_WR_FLT = 8'h42;
endpackage

// File: rtl/mc_perf_idmatch.sv
module mc_perf_idmatch #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_ready,
  input  logic [ID_W-1:0] req_id,
  input  logic [ID_W-1:0] flt_id,
  input  logic [ID_W-1:0] flt_mask,
  output logic            hit
);
  logic [ID_W-1:0] diff;
  assign diff = (req_id ^ flt_id) & flt_mask;
  assign hit  = req_valid && req_ready && (diff == '0);

  // R7
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && flt_mask == '0) |-> hit);
  // R6
  no_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |-> !hit);
endmodule

// File: rtl/mc_perf_evsel.sv
module mc_perf_evsel
  import mc_perf_pkg::*;
#(
  parameter int N_EVT = 64
) (
  input  logic [CODE_W-1:0] code,
  input  logic [N_EVT-1:0]  evt_pulse,
  input  logic              rd_hit,
  input  logic              wr_hit,
  output logic              sel
);
  localparam int IDX_W = $clog2(N_EVT);
  always_comb begin
    if (code == CODE_RD_FLT)       sel = rd_hit;
    else if (code == CODE_WR_FLT)  sel = wr_hit;
    else if (int'(code) < N_EVT)   sel = evt_pulse[code[IDX_W-1:0]];
    else                           sel = 1'b0;
  end
endmodule

// File: rtl/mc_perf_ctr.sv
module mc_perf_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = '1;
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_en)  cnt <= wr_data;
    else if (inc)    cnt <= cnt + 1'b1;
  end
  assign wrap = inc && !wr_en && (cnt == MAXV);

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  // R11
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt == $past(wr_data));
endmodule

// File: rtl/mc_perf_bank.sv
module mc_perf_bank
  import mc_perf_pkg::*;
#(
  parameter int N_EVT = NUM_EVT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_pulse,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int ADDR_W    = 4;
  localparam int CNT_BASE  = NUM_CNT;
  localparam int FILT_ADDR = 2 * NUM_CNT;
  localparam int STAT_ADDR = 2 * NUM_CNT + 1;

  logic              cfg_en   [NUM_CNT];
  logic [CODE_W-1:0] cfg_code [NUM_CNT];
  logic [CNT_W-1:0]  cnt      [NUM_CNT];
  logic [NUM_CNT-1:0] inc, wr_cnt, ctr_wrap, sel;
  logic [ID_W-1:0]   flt_id, flt_mask;
  logic              frozen, run, rd_hit, wr_hit, stat_wr, filt_wr;

  assign run     = cfg_en[0] && !frozen;
  assign stat_wr = reg_wr && reg_addr == ADDR_W'(STAT_ADDR);
  assign filt_wr = reg_wr && reg_addr == ADDR_W'(FILT_ADDR);

  mc_perf_idmatch #(.ID_W(ID_W)) u_rd_match (
    .clk(clk), .rst_n(rst_n), .req_valid(ar_valid), .req_ready(ar_ready),
    .req_id(ar_id), .flt_id(flt_id), .flt_mask(flt_mask), .hit(rd_hit));
  mc_perf_idmatch #(.ID_W(ID_W)) u_wr_match (
    .clk(clk), .rst_n(rst_n), .req_valid(aw_valid), .req_ready(aw_ready),
    .req_id(aw_id), .flt_id(flt_id), .flt_mask(flt_mask), .hit(wr_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_id   <= '0;
      flt_mask <= '0;
    end else if (filt_wr) begin
      flt_id   <= reg_wdata[ID_W-1:0];
      flt_mask <= reg_wdata[2*ID_W-1:ID_W];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_slot
    logic wr_cfg;
    assign wr_cfg    = reg_wr && reg_addr == ADDR_W'(i);
    assign wr_cnt[i] = reg_wr && reg_addr == ADDR_W'(CNT_BASE + i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_en[i]   <= 1'b0;
        cfg_code[i] <= '0;
      end else if (wr_cfg) begin
        cfg_en[i]   <= reg_wdata[0];
        cfg_code[i] <= reg_wdata[8 +: CODE_W];
      end
    end

    mc_perf_evsel #(.N_EVT(N_EVT)) u_sel (
      .code(cfg_code[i]), .evt_pulse(evt_pulse), .rd_hit(rd_hit),
      .wr_hit(wr_hit), .sel(sel[i]));

    if (i == 0) begin : g_cycle
      assign inc[i] = run;
    end else begin : g_event
      assign inc[i] = run && cfg_en[i] && sel[i];
    end

    mc_perf_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(inc[i]), .wr_en(wr_cnt[i]),
      .wr_data(reg_wdata[CNT_W-1:0]), .cnt(cnt[i]), .wrap(ctr_wrap[i]));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !wr_cnt[i]) |=> $stable(cnt[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       frozen <= 1'b0;
    else if (ctr_wrap[0])             frozen <= 1'b1;
    else if (stat_wr && reg_wdata[0]) frozen <= 1'b0;
  end
  assign irq = frozen;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == ADDR_W'(i))
        reg_rdata = {{(DATA_W-CODE_W-8){1'b0}}, cfg_code[i], 7'b0, cfg_en[i]};
      if (reg_addr == ADDR_W'(CNT_BASE + i))
        reg_rdata = cnt[i];
    end
    if (reg_addr == ADDR_W'(FILT_ADDR)) reg_rdata = {flt_mask, flt_id};
    if (reg_addr == ADDR_W'(STAT_ADDR)) reg_rdata = {{(DATA_W-1){1'b0}}, frozen};
  end

  // R4
  wrap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_wrap[0] |=> (irq && frozen));
  // R5
  quiet_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !ctr_wrap[0]) |=> !irq);
  // R2
  cycle_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_cnt[0]) |=> cnt[0] == $past(cnt[0]) + 1'b1);
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && stat_wr && reg_wdata[0]) |=> !frozen);
  // R3
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en[0] && !wr_cnt[1]) |=> $stable(cnt[1]));
endmodule

// File: tb/tb_mc_perf_bank.sv
module tb_mc_perf_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] evt_pulse = '0;
  logic        ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0;
  logic [15:0] ar_id = '0, aw_id = '0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit rand_on = 0;

  always #5 clk = ~clk;

  mc_perf_bank dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  // behavioural reference model
  logic [31:0] m_cnt [4];
  bit          m_en  [4];
  logic [7:0]  m_code[4];
  logic [15:0] m_fid, m_mask;
  bit          m_frz;

  function automatic bit m_event(input logic [7:0] code);
    if (code == 8'h41)
      return ar_valid && ar_ready && ((ar_id & m_mask) == (m_fid & m_mask));
    if (code == 8'h42)
      return aw_valid && aw_ready && ((aw_id & m_mask) == (m_fid & m_mask));
    if (code < 64) return evt_pulse[code];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_cnt[i] = 0; m_en[i] = 0; m_code[i] = 0;
      end
      m_fid = 0; m_mask = 0; m_frz = 0;
    end else begin
      bit go, roll;
      bit step [4];
      go = m_en[0] && !m_frz;
      for (int i = 0; i < 4; i++)
        step[i] = go && (i == 0 || (m_en[i] && m_event(m_code[i])));
      roll = step[0] && m_cnt[0] == 32'hFFFF_FFFF &&
             !(reg_wr && reg_addr == 4);
      for (int i = 0; i < 4; i++) if (step[i]) m_cnt[i] = m_cnt[i] + 1;
      if (reg_wr) begin
        if (reg_addr < 4) begin
          m_en[reg_addr] = reg_wdata[0];
          m_code[reg_addr] = reg_wdata[15:8];
        end else if (reg_addr < 8) m_cnt[reg_addr-4] = reg_wdata;
        else if (reg_addr == 8) begin
          m_fid = reg_wdata[15:0]; m_mask = reg_wdata[31:16];
        end
      end
      if (roll) m_frz = 1;
      else if (reg_wr && reg_addr == 9 && reg_wdata[0]) m_frz = 0;
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a < 4) return {16'h0, m_code[a], 7'h0, m_en[a]};
    if (a < 8) return m_cnt[a-4];
    if (a == 8) return {m_mask, m_fid};
    if (a == 9) return {31'h0, m_frz};
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    if (rst_n) begin
      chk(irq === m_frz, cur_req, "irq", {31'h0, irq}, {31'h0, m_frz});
      chk(reg_rdata === m_read(reg_addr), cur_req, "rdata", reg_rdata,
          m_read(reg_addr));
    end
    if (rand_on) begin
      evt_pulse = {$urandom, $urandom};
      ar_valid = $urandom; ar_ready = $urandom; ar_id = 16'($urandom);
      aw_valid = $urandom; aw_ready = $urandom; aw_id = 16'($urandom);
      if ($urandom % 2) ar_id = {ar_id[15:8], 8'h12};
      if ($urandom % 2) aw_id = {aw_id[15:8], 8'h12};
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic run_n(input int n, input logic [3:0] a);
    reg_addr = a;
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 10; a++) begin
      reg_addr = 4'(a);
      tick();
      chk(reg_rdata == 0, "R1", "reset read", reg_rdata, 0);
    end
    chk(irq == 0, "R1", "reset irq", {31'h0, irq}, 0);

    // R2 cycle counter ignores event code
    cur_req = "R2";
    wr(0, 32'h0000_0501);
    run_n(20, 4);
    chk(reg_rdata == 20, "R2", "cycle count", reg_rdata, 20);

    // R3 event counters and gating; R11 unmapped code counts nothing
    cur_req = "R3";
    wr(1, 32'h0000_0301);
    wr(2, 32'h0000_4601);   // code 0x46: unmapped (R11)
    wr(3, 32'h0000_3F00);   // disabled
    rand_on = 1;
    run_n(200, 5);
    cur_req = "R11";
    run_n(2, 6);
    chk(reg_rdata == 0, "R11", "unmapped code", reg_rdata, 0);
    cur_req = "R3";
    run_n(2, 7);
    chk(reg_rdata == 0, "R3", "disabled counter", reg_rdata, 0);
    wr(0, 32'h0);           // global disable
    run_n(50, 5);

    // R6/R7/R8 filtered request counts with shared filter
    cur_req = "R8";
    wr(8, 32'h00FF_0012);
    cur_req = "R6";
    wr(1, 32'h0000_4101);
    wr(2, 32'h0000_4201);
    wr(3, 32'h0000_4101);
    wr(5, 0); wr(6, 0); wr(7, 0);
    wr(0, 32'h1);
    run_n(300, 5);
    run_n(2, 6);
    cur_req = "R8";
    run_n(2, 7);
    cur_req = "R7";
    wr(8, 32'h0000_BEEF);   // mask 0: everything passes
    run_n(200, 6);
    rand_on = 0;
    ar_valid = 1; ar_ready = 0; aw_valid = 0; aw_ready = 1;
    wr(5, 0);
    run_n(10, 5);
    chk(reg_rdata == 0, "R6", "no handshake no count", reg_rdata, 0);

    // R5 silent wrap of counter 1
    cur_req = "R5";
    wr(1, 32'h0000_0701);
    wr(5, 32'hFFFF_FFFD);
    evt_pulse = '1;
    run_n(6, 5);
    chk(reg_rdata == 3, "R5", "wrapped value", reg_rdata, 3);
    chk(irq == 0, "R5", "no irq", {31'h0, irq}, 0);

    // R4/R10 counter 0 rollover, final increment, freeze
    cur_req = "R4";
    wr(0, 0);
    wr(4, 32'hFFFF_FFFC);
    wr(5, 32'h0000_0010);
    wr(0, 32'h1);
    run_n(3, 4);
    chk(irq == 0, "R4", "irq before rollover", {31'h0, irq}, 0);
    tick();
    chk(irq == 1, "R4", "irq after rollover", {31'h0, irq}, 1);
    reg_addr = 5;
    #1;
    chk(reg_rdata == 32'h14, "R10", "final increment", reg_rdata, 32'h14);
    cur_req = "R4";
    rand_on = 1;
    run_n(30, 5);
    chk(reg_rdata == 32'h14, "R4", "held while frozen", reg_rdata, 32'h14);

    // R9 release
    cur_req = "R9";
    wr(9, 32'h0);
    chk(irq == 1, "R9", "write 0 no effect", {31'h0, irq}, 1);
    wr(9, 32'h1);
    chk(irq == 0, "R9", "cleared", {31'h0, irq}, 0);
    run_n(50, 4);
    chk(reg_rdata == 50, "R9", "resumed", reg_rdata, 50);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule